// File: doc/BRIEF.md
# USB Host Start-of-Frame Frame Counter

This block keeps the 11-bit frame number of a USB host controller and paces the Start-of-Frame (SOF) tokens. Software reaches the frame number as two bytes and loads it before turning SOF generation on. Once the SOF enable input is high, a millisecond timer raises an SOF request once per period. The request carries the current frame number to a downstream token packet builder. The builder first accepts the request and later reports the token as sent. The frame number advances by one only when that completion is reported.

From the moment a request is raised until the builder reports completion, the block shows a busy status. Register writes made during that window are dropped, so the number being sent cannot change in flight. A soft clear input zeroes the frame number at any time.

A small state machine sequences each token. In `ST_IDLE` no request is outstanding. A timer tick moves it to `ST_REQ`, where the request is held. `sof_ack_i` moves it to `ST_BUSY`, which waits for the builder. `sof_done_i` returns it to `ST_IDLE` and advances the count. A tick that arrives while the machine is not in `ST_IDLE` is dropped.

Top module: `sof_frame_ctrl`

## Requirements
- R1: After `rst_n` is low, both register bytes read 0, `sof_req_o` is 0 and `sof_busy_o` is 0.
- R2: Reading with `reg_rd_hi_i`=0 returns frame bits 7..0. Reading with `reg_rd_hi_i`=1 returns frame bits 10..8 in data bits 2..0, with data bits 7..3 read as 0. A write with `reg_wr_hi_i`=0 loads frame bits 7..0 from data bits 7..0. A write with `reg_wr_hi_i`=1 loads frame bits 10..8 from data bits 2..0, and data bits 7..3 have no effect.
- R3: A one-cycle pulse on `soft_clr_i` sets the frame number to 0 at the next clock edge.
- R4: With `tok_sof_en_i` held high, the first SOF request rises at the CLKS_PER_MS-th rising clock edge that samples the enable high. Later requests rise at every further multiple of CLKS_PER_MS edges, as long as the machine is in `ST_IDLE` at that tick.
- R5: `sof_req_o` stays high until `sof_ack_i` is sampled high. While it is high, `sof_frame_o` equals the frame number.
- R6: `sof_busy_o` is high from the request through the edge that samples `sof_done_i`. A register write during busy has no effect.
- R7: Each `sof_done_i` pulse in `ST_BUSY` adds 1 to the frame number, and 0x7FF wraps to 0x000.
- R8: Driving `tok_sof_en_i` low stops the timer and clears its count, so a later enable again waits a full period. A request or transfer already in progress still completes through `sof_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr_i | input | 1 | Controller soft clear of the frame number |
| tok_sof_en_i | input | 1 | SOF token generation enable |
| reg_wr_en_i | input | 1 | Register byte write strobe |
| reg_wr_hi_i | input | 1 | Write byte select: 0 low byte, 1 high byte |
| reg_wr_data_i | input | 8 | Write data |
| reg_rd_hi_i | input | 1 | Read byte select: 0 low byte, 1 high byte |
| reg_rd_data_o | output | 8 | Read data for the selected byte |
| sof_req_o | output | 1 | SOF request to the token builder |
| sof_frame_o | output | 11 | Frame number carried with the request |
| sof_ack_i | input | 1 | Token builder accepted the request |
| sof_done_i | input | 1 | One-cycle pulse: SOF token sent |
| sof_busy_o | output | 1 | SOF in progress, writes locked |

## Verification
The bench builds the block with CLKS_PER_MS set to 8. This makes the first-request delay, the spacing between requests and the timer restart after a disable visible within a few dozen cycles, so each can be counted edge by edge. The frame width keeps its default of 11, so loading 0x7FF and completing one SOF exercises the real wrap point.

// File: rtl/sof_frame_pkg.sv
package sof_frame_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_BUSY = 2'd2
    } sof_state_e;

endpackage

// File: rtl/sof_ms_timer.sv
module sof_ms_timer #(
    parameter int unsigned CLKS_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CNT_W = (CLKS_PER_MS > 2) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_MS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    // R4: two ticks are never adjacent
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R8: a stopped timer produces no tick
    assert_stop_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !tick_o);

endmodule

// File: rtl/sof_req_fsm.sv
module sof_req_fsm
    import sof_frame_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ack_i,
    input  logic done_i,
    output logic req_o,
    output logic busy_o,
    output logic adv_o
);
    sof_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick_i) state_d = ST_REQ;
            ST_REQ:  if (ack_i)  state_d = ST_BUSY;
            ST_BUSY: if (done_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_o  = 1'b0;
        busy_o = 1'b0;
        adv_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ: begin
                req_o  = 1'b1;
                busy_o = 1'b1;
            end
            ST_BUSY: begin
                busy_o = 1'b1;
                adv_o  = done_i;
            end
            default: ;
        endcase
    end

    // R5: request holds until accepted
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);

    // R6: busy covers the request
    assert_busy_covers_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> busy_o);

    // R8: an accepted request stays busy until done
    assert_busy_to_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !req_o && !done_i) |=> busy_o);

endmodule

// File: rtl/sof_frame_reg.sv
module sof_frame_reg
    import sof_frame_pkg::*;
#(
    parameter int unsigned FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               lock_i,
    input  logic               adv_i,
    input  logic               wr_en_i,
    input  logic               wr_hi_i,
    input  logic [BYTE_W-1:0]  wr_data_i,
    input  logic               rd_hi_i,
    output logic [BYTE_W-1:0]  rd_data_o,
    output logic [FRAME_W-1:0] frame_o
);
    localparam int unsigned HI_W = FRAME_W - BYTE_W;

    logic [FRAME_W-1:0] frame_q, frame_d;
    logic [BYTE_W-1:0]  hi_byte;

    always_comb begin
        frame_d = frame_q;
        if (clear_i) begin
            frame_d = '0;
        end else if (adv_i) begin
            frame_d = frame_q + 1'b1;
        end else if (wr_en_i && !lock_i) begin
            if (wr_hi_i) begin
                frame_d = {wr_data_i[HI_W-1:0], frame_q[BYTE_W-1:0]};
            end else begin
                frame_d = {frame_q[FRAME_W-1:BYTE_W], wr_data_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else begin
            frame_q <= frame_d;
        end
    end

    generate
        if (HI_W < BYTE_W) begin : g_hi_pad
            assign hi_byte = {{(BYTE_W-HI_W){1'b0}}, frame_q[FRAME_W-1:BYTE_W]};
        end else begin : g_hi_full
            assign hi_byte = frame_q[FRAME_W-1:BYTE_W];
        end
    endgenerate

    assign rd_data_o = rd_hi_i ? hi_byte : frame_q[BYTE_W-1:0];
    assign frame_o   = frame_q;

    // R3: soft clear zeroes the count
    assert_soft_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (frame_o == '0));

    // R6: locked register only changes by advance or clear
    assert_write_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !adv_i && !clear_i) |=> $stable(frame_o));

    // R7: advance steps by one with wrap
    assert_advance_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clear_i) |=> (frame_o == $past(frame_o) + 1'b1));

endmodule

// File: rtl/sof_frame_ctrl.sv
module sof_frame_ctrl
    import sof_frame_pkg::*;
#(
    parameter int unsigned CLKS_PER_MS = 125000,
    parameter int unsigned FRAME_W     = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr_i,
    input  logic               tok_sof_en_i,
    input  logic               reg_wr_en_i,
    input  logic               reg_wr_hi_i,
    input  logic [7:0]         reg_wr_data_i,
    input  logic               reg_rd_hi_i,
    output logic [7:0]         reg_rd_data_o,
    output logic               sof_req_o,
    output logic [FRAME_W-1:0] sof_frame_o,
    input  logic               sof_ack_i,
    input  logic               sof_done_i,
    output logic               sof_busy_o
);
    logic tick;
    logic busy;
    logic adv;

    sof_ms_timer #(
        .CLKS_PER_MS(CLKS_PER_MS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (tok_sof_en_i),
        .tick_o(tick)
    );

    sof_req_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick),
        .ack_i (sof_ack_i),
        .done_i(sof_done_i),
        .req_o (sof_req_o),
        .busy_o(busy),
        .adv_o (adv)
    );

    sof_frame_reg #(
        .FRAME_W(FRAME_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (soft_clr_i),
        .lock_i   (busy),
        .adv_i    (adv),
        .wr_en_i  (reg_wr_en_i),
        .wr_hi_i  (reg_wr_hi_i),
        .wr_data_i(reg_wr_data_i),
        .rd_hi_i  (reg_rd_hi_i),
        .rd_data_o(reg_rd_data_o),
        .frame_o  (sof_frame_o)
    );

    assign sof_busy_o = busy;

    // R6: busy drops only after a completion pulse
    assert_busy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_busy_o && !sof_req_o && !sof_done_i) |=> sof_busy_o);

endmodule

// File: tb/sof_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module sof_frame_ctrl_tb_top;
    localparam int unsigned P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        sof_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic        req;
    logic [10:0] frame;
    logic        ack = 1'b0;
    logic        done = 1'b0;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sof_frame_ctrl #(.CLKS_PER_MS(P), .FRAME_W(11)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_clr_i(soft_clr), .tok_sof_en_i(sof_en),
        .reg_wr_en_i(wr_en), .reg_wr_hi_i(wr_hi), .reg_wr_data_i(wr_data),
        .reg_rd_hi_i(rd_hi), .reg_rd_data_o(rd_data), .sof_req_o(req),
        .sof_frame_o(frame), .sof_ack_i(ack), .sof_done_i(done), .sof_busy_o(busy)
    );

    // {write high byte, write data, expected frame}
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 8'hA5, 11'h0A5},
        {1'b1, 8'hFF, 11'h7A5},
        {1'b1, 8'h03, 11'h3A5},
        {1'b0, 8'h00, 11'h300},
        {1'b1, 8'hF8, 11'h000},
        {1'b0, 8'hFF, 11'h0FF},
        {1'b1, 8'h05, 11'h5FF},
        {1'b1, 8'h00, 11'h0FF}
    };

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr_byte(input logic hi, input logic [7:0] d);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_frame(output logic [10:0] f, output logic [7:0] hi_raw);
        logic [7:0] lo;
        rd_hi = 1'b0; #1; lo = rd_data;
        rd_hi = 1'b1; #1; hi_raw = rd_data;
        rd_hi = 1'b0;
        f = {hi_raw[2:0], lo};
    endtask

    task automatic chk_frame(input string tag, input int exp);
        logic [10:0] f;
        logic [7:0]  h;
        rd_frame(f, h);
        chk(tag, {h[7:3], f}, exp);
    endtask

    task automatic wait_first_req(input string tag);
        for (int k = 1; k < P; k++) begin
            @(negedge clk);
            chk({tag, " early req"}, req, 0);
        end
        @(negedge clk);
        chk({tag, " req on time"}, req, 1);
    endtask

    initial begin
        #1_600_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_frame("R1 frame bytes", 0);
        chk("R1 req", req, 0);
        chk("R1 busy", busy, 0);

        // R2 byte map vectors
        for (int i = 0; i < 8; i++) begin
            wr_byte(VEC[i][19], VEC[i][18:11]);
            chk_frame("R2 byte map", int'(VEC[i][10:0]));
        end

        // R3 soft clear
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
        chk_frame("R3 soft clear", 0);

        // R4/R5 first request
        wr_byte(1'b0, 8'hAB);
        wr_byte(1'b1, 8'h02);
        sof_en = 1'b1;
        wait_first_req("R4");
        chk("R5 frame on request", frame, 11'h2AB);
        chk("R6 busy with request", busy, 1);
        repeat (2) @(negedge clk);
        chk("R5 req held", req, 1);
        // R6 write while busy dropped
        wr_byte(1'b0, 8'h00);
        chk_frame("R6 locked write", 11'h2AB);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R5 req drops on ack", req, 0);
        chk("R6 busy after ack", busy, 1);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R6 busy released", busy, 0);
        chk_frame("R7 advance", 11'h2AC);

        // R4 periodic: next request at edge 2P
        repeat (P - 6) begin
            @(negedge clk);
            chk("R4 no early second req", req, 0);
        end
        @(negedge clk);
        chk("R4 second req", req, 1);
        chk("R5 frame second", frame, 11'h2AC);

        // R8 disable during request, it still completes
        sof_en = 1'b0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R8 busy after disable", busy, 1);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk_frame("R8 in-progress completes", 11'h2AD);
        begin
            int seen = 0;
            for (int k = 0; k < 3 * P; k++) begin
                @(negedge clk);
                if (req) seen++;
            end
            chk("R8 timer stopped", seen, 0);
        end

        // R7 wrap, R8 restart waits a full period
        wr_byte(1'b0, 8'hFF);
        wr_byte(1'b1, 8'h07);
        sof_en = 1'b1;
        wait_first_req("R8 restart");
        chk("R5 frame 7FF", frame, 11'h7FF);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        sof_en = 1'b0;
        chk_frame("R7 wrap", 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule